// File: doc/BRIEF.md
# Word-Addressed Bus Slave Register Front End

This block is the slave side of a shared on-chip peripheral bus for a streaming DSP peripheral. It registers every incoming bus signal, checks whether the registered address falls inside the peripheral's power-of-two address window, and answers each selected transfer with exactly one acknowledge cycle after a fixed latency. While the acknowledge is being formed it decodes per-register strobes from the word offset, the read/write flag and the acknowledge phase. It also places zero-extended read data on the return bus in the same cycle as the acknowledge.

Behind the block sit a one-bit run control, a coefficient FIFO that takes 12-bit values, and an output frame FIFO whose head word and full and empty flags can be read. The FIFOs and the data path are outside the block and connect through strobe, data and flag ports. The return data bus carries zeros in every cycle without an acknowledge, so several slaves can be OR-ed onto one bus. The retry, error and timeout-suppress responses are never used.

The acknowledge timing is held in a small enumerated state machine with three states. ST_IDLE waits for a registered in-window select. ST_ACK is the strobe cycle, in which the register enables fire and the read source is sampled. ST_RESP is the cycle in which the acknowledge and the read data are presented on the bus. The transitions are:
- IDLE_TO_ACK, taken when the peripheral is selected.
- ACK_TO_RESP, always taken.
- RESP_TO_IDLE, always taken.

Because ST_RESP never goes directly to ST_ACK, a select that is still held in the registered copy cannot produce a second acknowledge.

Top module: `opb_slave_regif`

## Requirements
- R1: While reset is high, and in the first cycle after it, ack, read data, run and all strobes are 0. Every registered bus input is cleared by reset.
- R2: A transfer is acknowledged only when select is high and address bits [31:8] equal the base address (default 0xFFFFFF00, a 256-byte window). Otherwise there is no ack, and no strobe or register changes.
- R3: The ack is high for exactly one cycle. It is sampled at the third falling clock edge after select and the address are driven (three rising edges of latency), for reads and writes alike.
- R4: Address bits [1:0] and the byte enables have no effect on decoding or data.
- R5: A read at word offset 0 (byte 0x0) returns the output FIFO head word on the return bus with the ack. It pulses the pop strobe for exactly one cycle, in the cycle before the ack.
- R6: A write at word offset 0 stores write-data bit 0 into the run output. The run output changes only on the edge that raises the ack.
- R7: A write at word offset 1 (byte 0x4) pulses the coefficient push strobe for exactly one cycle, the cycle before the ack, with write-data bits [11:0] on the coefficient port. Pop and push never fire together.
- R8: A read at word offset 1 returns the FIFO full flag in bit 0. A read at word offset 2 (byte 0x8) returns the empty flag in bit 0. All upper bits are 0.
- R9: The return bus is all zeros whenever ack is low, and during the ack of any write or of a read at an unmapped offset (word 3 and above).
- R10: The retry, error-ack and timeout-suppress outputs are always 0.
- R11: The run bit is write-only. Reading offset 0 returns FIFO data, not the run value. Writes to offsets 2 and above leave the run bit and both strobes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous bus reset, active high |
| bus_addr | input | 32 | Byte address from the master |
| bus_be | input | 4 | Byte enables (unused after registering) |
| bus_wdata | input | 32 | Write data from the master |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_sel | input | 1 | Master's address-valid select |
| bus_seq | input | 1 | Sequential-address hint (unused after registering) |
| sl_rdata | output | 32 | Return data, zero outside the ack cycle |
| sl_ack | output | 1 | Transfer acknowledge |
| sl_retry | output | 1 | Retry response, held 0 |
| sl_errack | output | 1 | Error acknowledge, held 0 |
| sl_toutsup | output | 1 | Timeout suppress, held 0 |
| run_o | output | 1 | Run control bit to the data path |
| coef_wdata | output | 12 | Coefficient value to the coefficient FIFO |
| coef_push | output | 1 | Coefficient FIFO write strobe |
| ofifo_pop | output | 1 | Output FIFO read strobe |
| ofifo_data | input | 32 | Output FIFO head word |
| ofifo_full | input | 1 | Output FIFO full flag |
| ofifo_empty | input | 1 | Output FIFO empty flag |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of the address:
- the ack lasts a single cycle;
- the return bus is zero without an ack;
- each pop or push strobe is followed by an ack on the next cycle;
- the two strobes are mutually exclusive;
- the run bit moves only on the edge that raises the ack.

The value-dependent behaviour can only be shown by the bench's scenarios. This covers the address window boundary, the offset map, flag placement and zero extension, the three-cycle latency, the effect of ignored address bits and byte enables, and the write-only nature of the run bit. The bench drives a seeded mix of in-window, out-of-window and unselected transfers and compares each against expected values that it computes itself.

// File: rtl/opb_regif_pkg.sv
package opb_regif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_RESP = 2'd2
    } ack_state_e;

    typedef enum logic [1:0] {
        RS_ZERO  = 2'd0,
        RS_FIFO  = 2'd1,
        RS_FULL  = 2'd2,
        RS_EMPTY = 2'd3
    } rd_src_e;

    // word offsets inside the window (byte offset / 4)
    localparam int unsigned WOFS_DATA  = 0; // read: FIFO head, write: run bit
    localparam int unsigned WOFS_FULL  = 1; // read: full flag, write: coefficient push
    localparam int unsigned WOFS_EMPTY = 2; // read: empty flag

endpackage

// File: rtl/opb_in_stage.sv
module opb_in_stage #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  addr_i,
    input  logic [BEW-1:0] be_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic           rnw_i,
    input  logic           sel_i,
    input  logic           seq_i,
    output logic [AW-1:0]  addr_q,
    output logic [BEW-1:0] be_q,
    output logic [DW-1:0]  wdata_q,
    output logic           rnw_q,
    output logic           sel_q,
    output logic           seq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rnw_q   <= 1'b0;
            sel_q   <= 1'b0;
            seq_q   <= 1'b0;
        end else begin
            addr_q  <= addr_i;
            be_q    <= be_i;
            wdata_q <= wdata_i;
            rnw_q   <= rnw_i;
            sel_q   <= sel_i;
            seq_q   <= seq_i;
        end
    end

endmodule

// File: rtl/opb_win_match.sv
module opb_win_match #(
    parameter int          AW        = 32,
    parameter int          WIN_BITS  = 8,
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_FF00
) (
    input  logic [AW-1:0] addr_q,
    input  logic          sel_q,
    output logic          psel
);

    localparam int TAGW = AW - WIN_BITS;
    localparam logic [TAGW-1:0] BASE_TAG = BASE_ADDR[AW-1:WIN_BITS];

    always_comb begin
        psel = sel_q && (addr_q[AW-1:WIN_BITS] == BASE_TAG);
    end

endmodule

// File: rtl/opb_ack_fsm.sv
module opb_ack_fsm
    import opb_regif_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic psel,
    output logic strobe_phase,
    output logic ack
);

    ack_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (psel) state_nx = ST_ACK;   // IDLE_TO_ACK
            ST_ACK:  state_nx = ST_RESP;            // ACK_TO_RESP
            ST_RESP: state_nx = ST_IDLE;            // RESP_TO_IDLE
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        strobe_phase = (state == ST_ACK);
        ack          = (state == ST_RESP);
    end

endmodule

// File: rtl/opb_reg_decode.sv
module opb_reg_decode
    import opb_regif_pkg::*;
#(
    parameter int OW = 6
) (
    input  logic [OW-1:0] word_ofs,
    input  logic          rnw_q,
    input  logic          strobe_phase,
    output rd_src_e       rd_src,
    output logic          pop,
    output logic          push,
    output logic          run_we
);

    localparam logic [OW-1:0] O_DATA  = OW'(WOFS_DATA);
    localparam logic [OW-1:0] O_FULL  = OW'(WOFS_FULL);
    localparam logic [OW-1:0] O_EMPTY = OW'(WOFS_EMPTY);

    always_comb begin
        rd_src = RS_ZERO;
        if (strobe_phase && rnw_q) begin
            if      (word_ofs == O_DATA)  rd_src = RS_FIFO;
            else if (word_ofs == O_FULL)  rd_src = RS_FULL;
            else if (word_ofs == O_EMPTY) rd_src = RS_EMPTY;
        end
        pop    = (rd_src == RS_FIFO);
        run_we = strobe_phase && !rnw_q && (word_ofs == O_DATA);
        push   = strobe_phase && !rnw_q && (word_ofs == O_FULL);
    end

endmodule

// File: rtl/opb_read_mux.sv
module opb_read_mux
    import opb_regif_pkg::*;
#(
    parameter int DW = 32
) (
    input  rd_src_e       rd_src,
    input  logic [DW-1:0] fifo_data,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    output logic [DW-1:0] rd_word
);

    always_comb begin
        unique case (rd_src)
            RS_ZERO:  rd_word = '0;
            RS_FIFO:  rd_word = fifo_data;
            RS_FULL:  rd_word = DW'(fifo_full);
            RS_EMPTY: rd_word = DW'(fifo_empty);
            default:  rd_word = '0;
        endcase
    end

endmodule

// File: rtl/opb_slave_regif.sv
module opb_slave_regif
    import opb_regif_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          BEW       = 4,
    parameter int          WIN_BITS  = 8,
    parameter int          COEF_W    = 12,
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_FF00
) (
    input  logic              clk,
    input  logic              bus_rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BEW-1:0]    bus_be,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rnw,
    input  logic              bus_sel,
    input  logic              bus_seq,
    output logic [DW-1:0]     sl_rdata,
    output logic              sl_ack,
    output logic              sl_retry,
    output logic              sl_errack,
    output logic              sl_toutsup,
    output logic              run_o,
    output logic [COEF_W-1:0] coef_wdata,
    output logic              coef_push,
    output logic              ofifo_pop,
    input  logic [DW-1:0]     ofifo_data,
    input  logic              ofifo_full,
    input  logic              ofifo_empty
);

    localparam int OW = WIN_BITS - 2;

    logic [AW-1:0]  addr_q;
    logic [BEW-1:0] be_q;
    logic [DW-1:0]  wdata_q;
    logic           rnw_q, sel_q, seq_q;
    logic           psel, strobe_phase, ack_w, run_we, run_q;
    rd_src_e        rd_src;
    logic [DW-1:0]  rd_word, rdata_q;
    logic           unused_inputs;

    opb_in_stage #(.AW(AW), .DW(DW), .BEW(BEW)) u_in (
        .clk(clk), .rst(bus_rst),
        .addr_i(bus_addr), .be_i(bus_be), .wdata_i(bus_wdata),
        .rnw_i(bus_rnw), .sel_i(bus_sel), .seq_i(bus_seq),
        .addr_q(addr_q), .be_q(be_q), .wdata_q(wdata_q),
        .rnw_q(rnw_q), .sel_q(sel_q), .seq_q(seq_q)
    );

    opb_win_match #(.AW(AW), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)) u_win (
        .addr_q(addr_q), .sel_q(sel_q), .psel(psel)
    );

    opb_ack_fsm u_fsm (
        .clk(clk), .rst(bus_rst), .psel(psel),
        .strobe_phase(strobe_phase), .ack(ack_w)
    );

    opb_reg_decode #(.OW(OW)) u_dec (
        .word_ofs(addr_q[WIN_BITS-1:2]), .rnw_q(rnw_q),
        .strobe_phase(strobe_phase), .rd_src(rd_src),
        .pop(ofifo_pop), .push(coef_push), .run_we(run_we)
    );

    opb_read_mux #(.DW(DW)) u_mux (
        .rd_src(rd_src), .fifo_data(ofifo_data),
        .fifo_full(ofifo_full), .fifo_empty(ofifo_empty),
        .rd_word(rd_word)
    );

    // run bit: write-only control
    always_ff @(posedge clk) begin
        if (bus_rst)     run_q <= 1'b0;
        else if (run_we) run_q <= wdata_q[0];
    end

    // return data register, cleared by the acknowledge cycle
    always_ff @(posedge clk) begin
        if (bus_rst || ack_w) rdata_q <= '0;
        else                  rdata_q <= rd_word;
    end

    assign unused_inputs = ^{be_q, seq_q, addr_q[1:0], wdata_q[DW-1:COEF_W]};

    assign sl_rdata   = rdata_q;
    assign sl_ack     = ack_w;
    assign sl_retry   = 1'b0;
    assign sl_errack  = 1'b0;
    assign sl_toutsup = 1'b0;
    assign run_o      = run_q;
    assign coef_wdata = wdata_q[COEF_W-1:0];

endmodule

// File: rtl/opb_regif_chk.sv
module opb_regif_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          bus_rst,
    input logic          sl_ack,
    input logic [DW-1:0] sl_rdata,
    input logic          run_o,
    input logic          coef_push,
    input logic          ofifo_pop
);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (bus_rst)
        sl_ack |=> !sl_ack);                                   // R3

    AST_RDATA_ZERO_IDLE: assert property (@(posedge clk) disable iff (bus_rst)
        !sl_ack |-> (sl_rdata == '0));                         // R9

    AST_POP_THEN_ACK: assert property (@(posedge clk) disable iff (bus_rst)
        ofifo_pop |=> sl_ack);                                 // R5

    AST_PUSH_THEN_ACK: assert property (@(posedge clk) disable iff (bus_rst)
        coef_push |=> sl_ack);                                 // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (bus_rst)
        $onehot0({coef_push, ofifo_pop}));                     // R7

    AST_RUN_ON_ACK: assert property (@(posedge clk) disable iff (bus_rst)
        (run_o != $past(run_o)) |-> sl_ack);                   // R6

endmodule

bind opb_slave_regif opb_regif_chk #(.DW(DW)) u_chk (
    .clk(clk), .bus_rst(bus_rst), .sl_ack(sl_ack), .sl_rdata(sl_rdata),
    .run_o(run_o), .coef_push(coef_push), .ofifo_pop(ofifo_pop)
);

// File: tb/opb_slave_regif_tb.sv
`timescale 1ns/1ps
module opb_slave_regif_tb;

    localparam logic [31:0] BASE = 32'hFFFF_FF00;

    logic        clk = 1'b0;
    logic        bus_rst;
    logic [31:0] bus_addr, bus_wdata, ofifo_data;
    logic [3:0]  bus_be;
    logic        bus_rnw, bus_sel, bus_seq, ofifo_full, ofifo_empty;
    logic [31:0] sl_rdata;
    logic        sl_ack, sl_retry, sl_errack, sl_toutsup, run_o, coef_push, ofifo_pop;
    logic [11:0] coef_wdata;

    int n_chk = 0, n_fail = 0;
    int pops = 0, pushes = 0;
    logic [11:0] last_coef = '0;
    logic run_exp = 1'b0;

    always #4 clk = ~clk;

    opb_slave_regif u_dut (
        .clk(clk), .bus_rst(bus_rst), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rnw(bus_rnw), .bus_sel(bus_sel), .bus_seq(bus_seq),
        .sl_rdata(sl_rdata), .sl_ack(sl_ack), .sl_retry(sl_retry), .sl_errack(sl_errack),
        .sl_toutsup(sl_toutsup), .run_o(run_o), .coef_wdata(coef_wdata),
        .coef_push(coef_push), .ofifo_pop(ofifo_pop), .ofifo_data(ofifo_data),
        .ofifo_full(ofifo_full), .ofifo_empty(ofifo_empty)
    );

    always @(negedge clk) begin
        if (ofifo_pop) pops++;
        if (coef_push) begin
            pushes++;
            last_coef = coef_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [31:0] a);
        return a[31:8] == BASE[31:8];
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        case (a[7:2])
            6'd0:    return ofifo_data;
            6'd1:    return {31'b0, ofifo_full};
            6'd2:    return {31'b0, ofifo_empty};
            default: return 32'b0;
        endcase
    endfunction

    task automatic xfer(input logic [31:0] a, input logic rnw, input logic [31:0] wd,
                        input logic [3:0] be, input logic sel);
        int lat = 0;
        bit got = 0;
        logic [31:0] rd = '0, exp_rd;
        int pops0 = pops, push0 = pushes;
        bit hit = sel && in_win(a);
        exp_rd = (rnw) ? exp_read(a) : 32'b0;
        @(negedge clk);
        bus_addr = a; bus_rnw = rnw; bus_wdata = wd; bus_be = be; bus_sel = sel;
        bus_seq = be[0];
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            lat++;
            if (sl_ack) begin got = 1; rd = sl_rdata; break; end
        end
        bus_sel = 1'b0; bus_addr = '0; bus_wdata = '0;
        check(got == hit, "R2 ack presence", 32'(got), 32'(hit));
        if (hit) begin
            check(lat == 3, "R3 latency", 32'(lat), 32'd3);
            check(rd == exp_rd, (rnw ? "R5/R8 read data" : "R9 write returns zero"), rd, exp_rd);
            if (!rnw && a[7:2] == 6'd0) run_exp = wd[0];
            check(pops - pops0 == ((rnw && a[7:2] == 6'd0) ? 1 : 0), "R5 pop count",
                  32'(pops - pops0), 32'((rnw && a[7:2] == 6'd0) ? 1 : 0));
            check(pushes - push0 == ((!rnw && a[7:2] == 6'd1) ? 1 : 0), "R7 push count",
                  32'(pushes - push0), 32'((!rnw && a[7:2] == 6'd1) ? 1 : 0));
            if (!rnw && a[7:2] == 6'd1)
                check(last_coef == wd[11:0], "R7 coef data", 32'(last_coef), 32'(wd[11:0]));
        end else begin
            check(pops == pops0 && pushes == push0, "R2 no strobe outside window",
                  32'(pops - pops0 + pushes - push0), 32'd0);
        end
        check(run_o == run_exp, "R6/R11 run bit", 32'(run_o), 32'(run_exp));
        @(negedge clk);
        check(!sl_ack && sl_rdata == '0, "R3/R9 idle after ack", {sl_ack, sl_rdata[30:0]}, 32'd0);
        check(!sl_retry && !sl_errack && !sl_toutsup, "R10 side responses",
              {29'b0, sl_retry, sl_errack, sl_toutsup}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        bus_rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_be = '0;
        bus_rnw = 1'b0; bus_sel = 1'b0; bus_seq = 1'b0;
        ofifo_data = 32'hA5A5_0001; ofifo_full = 1'b0; ofifo_empty = 1'b1;
        repeat (3) @(negedge clk);
        check(!sl_ack && sl_rdata == '0 && !run_o && !coef_push && !ofifo_pop, "R1 reset state",
              {sl_ack, run_o, coef_push, ofifo_pop, sl_rdata[27:0]}, 32'd0);
        bus_rst = 1'b0;
        @(negedge clk);
        check(!sl_ack && sl_rdata == '0 && !run_o, "R1 after reset", {sl_ack, run_o, 30'b0}, 32'd0);

        // directed corners
        xfer(BASE + 32'h0, 1'b0, 32'h0000_0001, 4'hF, 1'b1);          // R6 run set
        xfer(BASE + 32'h0, 1'b1, 32'h0, 4'hF, 1'b1);                  // R11 read returns FIFO data
        xfer(BASE + 32'h3, 1'b0, 32'hFFFF_F000, 4'h0, 1'b1);          // R4 low bits ignored, run cleared
        xfer(BASE + 32'h5, 1'b0, 32'h1234_5ABC, 4'h1, 1'b1);          // R7 push, R4
        xfer(BASE + 32'h8, 1'b0, 32'h0000_0001, 4'hF, 1'b1);          // R11 no effect
        xfer(BASE + 32'hFC, 1'b0, 32'h0000_0001, 4'hF, 1'b1);         // R11 no effect, window top
        xfer(BASE + 32'hFC, 1'b1, 32'h0, 4'hF, 1'b1);                 // R9 unmapped read
        xfer(BASE - 32'h4, 1'b1, 32'h0, 4'hF, 1'b1);                  // R2 just below window
        xfer(BASE + 32'h0, 1'b0, 32'h1, 4'hF, 1'b0);                  // R2 select low
        ofifo_full = 1'b1; ofifo_empty = 1'b0;
        xfer(BASE + 32'h4, 1'b1, 32'h0, 4'hF, 1'b1);                  // R8 full
        xfer(BASE + 32'h8, 1'b1, 32'h0, 4'hF, 1'b1);                  // R8 empty

        // seeded random mix
        for (int k = 0; k < 80; k++) begin
            logic [31:0] a;
            logic [31:0] r = $urandom;
            ofifo_data  = $urandom;
            ofifo_full  = r[0];
            ofifo_empty = r[1];
            a = (r[4:2] == 3'd0) ? $urandom : (BASE | {24'b0, (r[5] ? 6'($urandom) : 6'(r[7:6])), r[9:8]});
            xfer(a, r[10], $urandom, 4'($urandom), r[12:11] != 2'b00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule